// File: doc/BRIEF.md
# Chained-Retrigger Watchdog Counter Bank

This block holds four 64-bit down-counters behind a 32-bit register port. Any one of them can be chosen to raise a watchdog reset request when it runs out. Each counter has a control word and an initial value. The initial value is written as two 32-bit halves. The count value is read back the same way, and the upper half is frozen when the lower half is read, so the two halves always belong together.

A counter can be set to reload and restart whenever the counter below it in the ring reaches end count. Software then keeps the watchdog alive without ever stopping it. The watchdog counter is armed in this reload mode. The counter below it is set up as one-shot with a count of zero. Each keep-alive is then two control writes to that lower counter: clear enable, then set enable. Re-enabling makes the lower counter fire end count at once, and that event restarts the watchdog counter from its full initial value.

Top module: `wdt_cntr_bank`

## Requirements
- R1: After reset, the control words of counters 0 and 1 read 0x0000_0200 (disabled). Those of counters 2 and 3 read 0x0000_0203 (enabled and active). The select register reads 0, and `end_pulse` and `wdog_rst_req` are low.
- R2: Counter n's registers sit at byte address n×0x10: control at +0x0, low count at +0x4, high count at +0x8. The watchdog select register is at 0x40. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R3: Control word layout: bit 0 enable; bit 1 active, read-only (a written 1 is ignored); bits 3:2 mode, where 11 reloads on trigger and any other value is one-shot; bits 7:4 trigger source, where 5 selects the previous counter (counter 0's previous counter is counter 3); bits 15:8 prescaler. Bits 31:16 read 0.
- R4: Setting enable from 0 to 1 on a one-shot counter loads initial value N and sets active. The counter steps down once every P cycles, where P is the prescaler with values below 2 treated as 2. `end_pulse[n]` rises N×P+1 cycles after the enabling write, lasts one cycle, and clears active.
- R5: A one-shot counter with initial value 0 gives its end pulse one cycle after enable. Clearing and setting enable again gives a new pulse.
- R6: In reload mode, enabling alone does not start the counter. Each end pulse of the previous counter (trigger source 5) loads the full 64-bit initial value and starts counting. Reaching zero gives one end pulse, and the counter then stops until the next trigger.
- R7: A read of the low count word returns the low 32 bits of the current count and captures the high 32 bits. A later read of the high word returns the captured value.
- R8: Clearing enable halts counting and clears active. The current count and the initial value are kept. Enabling again restarts from the initial value.
- R9: The select register (bits 3:0, bit n = counter n) chooses the watchdog source. `wdog_rst_req` rises one cycle after the end pulse of a selected, enabled counter and stays high until reset, even if the select is cleared. With select 0 it never rises.
- R10: While keep-alives arrive faster than the watchdog period, `wdog_rst_req` stays low and the watchdog counter stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| end_pulse | output | 4 | One-cycle end-count pulse per counter |
| wdog_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
Any wrong internal state in this block shows up at the ports as timing. An off-by-one in the prescaler or in the zero detect moves an end pulse by exactly P cycles or by one cycle. A stale initial value, or a retrigger that is lost, shows up as a watchdog request at the wrong time. Every measurement is therefore an exact cycle count from the enabling write to the pulse or the request. Those errors appear within tens of cycles. A wrong capture of the high half only shows up when the count crosses a 32-bit boundary between the low and high reads, so one case is built to cross it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned PRESC_W   = 8;
  localparam int unsigned PRESC_MIN = 2;
  localparam logic [1:0]  MODE_RELOAD = 2'b11;
  localparam logic [3:0]  TRIG_PREV   = 4'd5;
  localparam logic [3:0]  OFS_CTRL = 4'h0;
  localparam logic [3:0]  OFS_LO   = 4'h4;
  localparam logic [3:0]  OFS_HI   = 4'h8;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [3:0]         trig;
    logic [1:0]         mode;
    logic               en;
  } ctl_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter bit          RST_EN = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          rd_lo,
  input  logic [DW-1:0] wdata,
  input  logic          prev_end,
  output logic [15:0]   ctrl_word,
  output logic [DW-1:0] cnt_lo,
  output logic [DW-1:0] hold_hi,
  output logic          en_o,
  output logic          end_o
);
  localparam int unsigned CW = 2 * DW;

  ctl_t               ctl;
  ctl_t               ctl_new;
  logic               active;
  logic               end_r;
  logic [CW-1:0]      init_v;
  logic [CW-1:0]      cnt;
  logic [PRESC_W-1:0] pcnt;
  logic [PRESC_W-1:0] peff;
  logic [DW-1:0]      hold;
  logic               tick;
  logic               en_rise;
  logic               trig_hit;

  always_comb begin
    ctl_new.en    = wdata[0];
    ctl_new.mode  = wdata[3:2];
    ctl_new.trig  = wdata[7:4];
    ctl_new.presc = wdata[8 +: PRESC_W];
  end

  assign peff     = (ctl.presc < PRESC_W'(PRESC_MIN)) ? PRESC_W'(PRESC_MIN) : ctl.presc;
  assign tick     = (pcnt >= peff - PRESC_W'(1));
  assign en_rise  = wr_ctrl && ctl_new.en && !ctl.en;
  assign trig_hit = ctl.en && (ctl.mode == MODE_RELOAD) && (ctl.trig == TRIG_PREV) && prev_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl.presc <= PRESC_W'(PRESC_MIN);
      ctl.trig  <= '0;
      ctl.mode  <= '0;
      ctl.en    <= RST_EN;
      active    <= RST_EN;
      init_v    <= '1;
      cnt       <= '1;
      pcnt      <= '0;
      hold      <= '0;
      end_r     <= 1'b0;
    end else begin
      end_r <= 1'b0;
      if (wr_lo) init_v[DW-1:0]  <= wdata;
      if (wr_hi) init_v[CW-1:DW] <= wdata;
      if (rd_lo) hold <= cnt[CW-1:DW];
      if (wr_ctrl) ctl <= ctl_new;
      if (wr_ctrl && !ctl_new.en) begin
        active <= 1'b0;
      end else if ((en_rise && ctl_new.mode != MODE_RELOAD) || trig_hit) begin
        cnt    <= init_v;
        active <= 1'b1;
        pcnt   <= '0;
      end else if (active) begin
        if (cnt == '0) begin
          end_r  <= 1'b1;
          active <= 1'b0;
        end else if (tick) begin
          cnt  <= cnt - CW'(1);
          pcnt <= '0;
        end else begin
          pcnt <= pcnt + PRESC_W'(1);
        end
      end
    end
  end

  assign ctrl_word = {ctl.presc, ctl.trig, ctl.mode, active, ctl.en};
  assign cnt_lo    = cnt[DW-1:0];
  assign hold_hi   = hold;
  assign en_o      = ctl.en;
  assign end_o     = end_r;

  // R4
  end_single_chk: assert property (@(posedge clk) disable iff (rst) end_r |=> !end_r);
  // R4
  end_at_zero_chk: assert property (@(posedge clk) disable iff (rst) end_r |-> (cnt == '0) && !active);
  // R8
  active_needs_en_chk: assert property (@(posedge clk) disable iff (rst) active |-> ctl.en);
  // R6
  reload_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(active) && ctl.mode == MODE_RELOAD && !$past(wr_ctrl)) |-> $past(prev_end));
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry #(
  parameter int unsigned NC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sel,
  input  logic [NC-1:0] sel_wdata,
  input  logic [NC-1:0] end_i,
  input  logic [NC-1:0] en_i,
  output logic [NC-1:0] sel_o,
  output logic          req_o
);
  logic [NC-1:0] sel;
  logic          req;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
      req <= 1'b0;
    end else begin
      if (wr_sel) sel <= sel_wdata;
      if (|(end_i & sel & en_i)) req <= 1'b1;
    end
  end

  assign sel_o = sel;
  assign req_o = req;

  // R9
  req_sticky_chk: assert property (@(posedge clk) disable iff (rst) req |=> req);
  // R9
  req_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(req) |-> $past(|(end_i & sel)));
endmodule

// File: rtl/wdt_cntr_bank.sv
module wdt_cntr_bank
  import wdt_pkg::*;
#(
  parameter int unsigned NC          = 4,
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 8,
  parameter logic [3:0]  RST_EN_MASK = 4'b1100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [NC-1:0] end_pulse,
  output logic          wdog_rst_req
);
  localparam int unsigned GW = AW - 4;

  logic [GW-1:0]         grp;
  logic [3:0]            ofs;
  logic [NC-1:0][15:0]   ctrl_w;
  logic [NC-1:0][DW-1:0] lo_w;
  logic [NC-1:0][DW-1:0] hi_w;
  logic [NC-1:0]         en_w;
  logic [NC-1:0]         end_w;
  logic [NC-1:0]         sel_w;
  logic                  wr_sel;
  logic [DW-1:0]         rd_mux;
  logic [DW-1:0]         rdata_r;

  assign grp    = reg_addr[AW-1:4];
  assign ofs    = reg_addr[3:0];
  assign wr_sel = reg_wr && (grp == GW'(NC)) && (ofs == OFS_CTRL);

  for (genvar i = 0; i < NC; i++) begin : g_cnt
    wdt_counter #(.DW(DW), .RST_EN(RST_EN_MASK[i])) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .wr_ctrl  (reg_wr && grp == GW'(i) && ofs == OFS_CTRL),
      .wr_lo    (reg_wr && grp == GW'(i) && ofs == OFS_LO),
      .wr_hi    (reg_wr && grp == GW'(i) && ofs == OFS_HI),
      .rd_lo    (reg_rd && grp == GW'(i) && ofs == OFS_LO),
      .wdata    (reg_wdata),
      .prev_end (end_w[(i + NC - 1) % NC]),
      .ctrl_word(ctrl_w[i]),
      .cnt_lo   (lo_w[i]),
      .hold_hi  (hi_w[i]),
      .en_o     (en_w[i]),
      .end_o    (end_w[i])
    );
  end

  wdt_expiry #(.NC(NC)) u_exp (
    .clk      (clk),
    .rst      (rst),
    .wr_sel   (wr_sel),
    .sel_wdata(reg_wdata[NC-1:0]),
    .end_i    (end_w),
    .en_i     (en_w),
    .sel_o    (sel_w),
    .req_o    (wdog_rst_req)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NC; i++) begin
      if (grp == GW'(i)) begin
        case (ofs)
          OFS_CTRL: rd_mux = {{(DW-16){1'b0}}, ctrl_w[i]};
          OFS_LO:   rd_mux = lo_w[i];
          OFS_HI:   rd_mux = hi_w[i];
          default:  rd_mux = '0;
        endcase
      end
    end
    if (grp == GW'(NC) && ofs == OFS_CTRL) rd_mux = {{(DW-NC){1'b0}}, sel_w};
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_r <= '0;
    else if (reg_rd) rdata_r <= rd_mux;
  end

  assign reg_rdata = rdata_r;
  assign end_pulse = end_w;

  // R2
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst) !$past(reg_rd) |-> $stable(reg_rdata));
endmodule

// File: tb/sim_wdt_cntr_bank.sv
`timescale 1ns/1ps
module sim_wdt_cntr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  end_pulse;
  logic        wdog_rst_req;

  int total = 0;
  int bad   = 0;
  logic [31:0] d;
  int n;

  // {prescaler, initial value, expected cycles to end pulse}
  localparam logic [39:0] VEC [8] = '{
    {8'd2, 16'd0, 16'd1},
    {8'd2, 16'd1, 16'd3},
    {8'd2, 16'd5, 16'd11},
    {8'd3, 16'd4, 16'd13},
    {8'd0, 16'd3, 16'd7},
    {8'd1, 16'd2, 16'd5},
    {8'd5, 16'd3, 16'd16},
    {8'd8, 16'd2, 16'd17}
  };

  wdt_cntr_bank u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .end_pulse(end_pulse),
    .wdog_rst_req(wdog_rst_req)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wait_end(input int idx, output int cyc);
    cyc = 0;
    while (!end_pulse[idx] && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic ping();
    wr(8'h00, 32'h0000_0200);
    wr(8'h00, 32'h0000_0201);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 end_pulse", end_pulse, 4'h0);
    check("R1 wdog", wdog_rst_req, 1'b0);
    rd(8'h00, d); check("R1 ctrl0", d, 32'h0200);
    rd(8'h10, d); check("R1 ctrl1", d, 32'h0200);
    rd(8'h20, d); check("R1 ctrl2", d, 32'h0203);
    rd(8'h30, d); check("R1 ctrl3", d, 32'h0203);
    rd(8'h40, d); check("R1 sel", d, 32'h0);

    // R2 address decode: disable counter 3 only
    wr(8'h30, 32'h0000_0200);
    rd(8'h30, d); check("R2 ctrl3 after write", d, 32'h0200);
    rd(8'h20, d); check("R2 ctrl2 untouched", d, 32'h0203);

    // R4 / R5 table of one-shot timings on counter 0
    for (int k = 0; k < 8; k++) begin
      wr(8'h00, 32'h0);
      wr(8'h04, {16'h0, VEC[k][31:16]});
      wr(8'h08, 32'h0);
      wr(8'h00, {16'h0, VEC[k][39:32], 8'h01});
      wait_end(0, n);
      check(VEC[k][31:16] == 0 ? "R5 zero count timing" : "R4 end timing", n, {48'h0, VEC[k][15:0]});
      @(negedge clk);
      check("R4 pulse width", end_pulse[0], 1'b0);
      rd(8'h00, d); check("R4 active cleared", d, {16'h0, VEC[k][39:32], 8'h01});
    end

    // R3 field layout, read-only active bit, upper bits zero
    wr(8'h10, 32'hFFFF_A55E);
    rd(8'h10, d); check("R3 ctrl layout", d, 32'h0000_A55C);

    // R6 reload mode does not start on enable
    wr(8'h14, 32'd5);
    wr(8'h18, 32'd0);
    wr(8'h10, 32'h0000_025D);
    repeat (3) @(negedge clk);
    rd(8'h10, d); check("R6 idle after enable", d, 32'h025D);

    // R6 retrigger from counter 0; R9 select 0 gives no request
    wr(8'h04, 32'd0);
    ping();
    wait_end(1, n); check("R6 retrigger timing", n, 13);
    @(negedge clk); @(negedge clk);
    check("R9 no request with select 0", wdog_rst_req, 1'b0);
    rd(8'h10, d); check("R6 stops at zero", d, 32'h025D);

    // R6 full 64-bit reload
    wr(8'h14, 32'd7);
    wr(8'h18, 32'd1);
    ping();
    repeat (3) @(negedge clk);
    rd(8'h14, d); check("R6 reload low", d, 32'd7);
    rd(8'h18, d); check("R6 reload high", d, 32'd1);

    // R10 keep-alive
    wr(8'h14, 32'd20);
    wr(8'h18, 32'd0);
    wr(8'h40, 32'h2);
    rd(8'h40, d); check("R9 select readback", d, 32'h2);
    for (int k = 0; k < 6; k++) begin
      ping();
      repeat (30) @(negedge clk);
    end
    check("R10 no request while pinged", wdog_rst_req, 1'b0);
    rd(8'h10, d); check("R10 watchdog active", d, 32'h025F);

    // R9 expiry timing and stickiness
    ping();
    n = 0;
    while (!wdog_rst_req && n < 3000) begin @(negedge clk); n++; end
    check("R9 request timing", n, 44);
    wr(8'h40, 32'h0);
    repeat (10) @(negedge clk);
    check("R9 request sticky", wdog_rst_req, 1'b1);

    // R7 high-word capture across a 32-bit boundary
    wr(8'h00, 32'h0200);
    wr(8'h04, 32'd1);
    wr(8'h08, 32'd1);
    wr(8'h00, 32'h0201);
    rd(8'h04, d); check("R7 low first", d, 32'h1);
    repeat (5) @(negedge clk);
    rd(8'h08, d); check("R7 held high", d, 32'h1);
    rd(8'h04, d); check("R7 low second", d, 32'hFFFF_FFFE);
    rd(8'h08, d); check("R7 high second", d, 32'h0);

    // R8 disable halts and keeps initial value
    wr(8'h00, 32'h0200);
    wr(8'h04, 32'd3);
    wr(8'h08, 32'd0);
    wr(8'h00, 32'h0201);
    repeat (3) @(negedge clk);
    wr(8'h00, 32'h0200);
    rd(8'h00, d); check("R8 active cleared", d, 32'h0200);
    rd(8'h04, d); check("R8 count frozen", d, 32'd2);
    repeat (5) @(negedge clk);
    rd(8'h04, d); check("R8 count still frozen", d, 32'd2);
    check("R8 no end while disabled", end_pulse[0], 1'b0);
    wr(8'h00, 32'h0201);
    wait_end(0, n); check("R8 restart from initial", n, 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule